// File: doc/BRIEF.md
# Floating-Point Compare and Flag Unit

This block compares two IEEE-754 operands, held either as binary32 (in the low 32 bits of each operand bus) or as binary64, and writes the outcome of one Boolean predicate into a single status flag. It produces no register result. The only thing it writes is the flag, together with a one-cycle write enable that the surrounding pipeline uses to update its condition bit.

An 8-bit function code chooses the predicate. The code selects equal, not-equal, greater, greater-or-equal, less or less-or-equal. It also selects whether the predicate is ordered or an "unordered-or" variant that reports true whenever a NaN is present. A separate code tests for the unordered case alone. A separate precision input must agree with the precision that the code names. Codes outside the compare set leave the flag untouched. Signalling-NaN exceptions are not raised.

Top module: `fcmp_flag_unit`

## Requirements
- R1: Code bit 4 selects binary64 (1) or binary32 (0), with binary32 operands taken from bits [31:0]. Code bit 5 selects unordered-or (1) or ordered (0). Code bits [3:0] = 8, 9, 10, 11, 12, 13 select eq, ne, gt, ge, lt, le respectively. So 0x08..0x0D, 0x18..0x1D, 0x28..0x2D and 0x38..0x3D are the compare codes.
- R2: An accepted request (in_valid high with a legal code) raises flag_we for exactly the next cycle, and flag_q carries the result in that same cycle.
- R3: Ordered predicates other than ne give 0 when either operand is NaN (exponent all ones, fraction nonzero). Ordered ne gives 1.
- R4: An unordered-or predicate gives (either operand NaN) OR (the ordered predicate result).
- R5: Codes 0x2E (binary32) and 0x3E (binary64) give 1 exactly when at least one operand is NaN.
- R6: +0 and -0 compare as equal under every predicate.
- R7: Ordering follows the real values across signs. Among negative operands, a larger magnitude is the smaller value.
- R8: A request with code bits [7:6] nonzero, a low nibble outside 8..13 (other than 14 with bit 5 set), or code bit 4 differing from prec_dbl causes no flag write.
- R9: After synchronous reset flag_q and flag_we are 0.
- R10: flag_q keeps its value in every cycle in which flag_we is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe |
| func_code | input | 8 | Compare function code |
| prec_dbl | input | 1 | 1 = binary64 operands, 0 = binary32 |
| opnd_a | input | 64 | Left operand |
| opnd_b | input | 64 | Right operand |
| flag_q | output | 1 | Registered compare flag |
| flag_we | output | 1 | Flag write enable, one cycle per accepted request |

## Verification
Two functions can decide the same flag in the same cycle: NaN detection and the magnitude ordering. This happens when a NaN operand meets a predicate that the raw bit ordering alone would report as true or false. The bench provokes the overlap by drawing operands from a pool of specials: NaNs, infinities, both zeros, copies and negations of the other operand. It applies each pool pair under ordered, unordered-or and pure unordered codes in both precisions. A reference function, built on a monotonic integer key and a separate NaN test, judges each result.

// File: rtl/fcmp_pkg.sv
package fcmp_pkg;
  typedef enum logic [3:0] {
    PRD_EQ = 4'h8,
    PRD_NE = 4'h9,
    PRD_GT = 4'hA,
    PRD_GE = 4'hB,
    PRD_LT = 4'hC,
    PRD_LE = 4'hD,
    PRD_UN = 4'hE
  } pred_e;
endpackage

// File: rtl/fcmp_decode.sv
module fcmp_decode
  import fcmp_pkg::*;
(
  input  logic [7:0] code,
  input  logic       prec_dbl,
  output logic       legal,
  output logic       unord_or,
  output pred_e      pred
);
  logic [3:0] nib;
  logic       nib_ok;

  assign nib      = code[3:0];
  assign unord_or = code[5];
  assign pred     = pred_e'(nib);
  assign nib_ok   = ((nib >= 4'h8) && (nib <= 4'hD)) || ((nib == 4'hE) && code[5]);
  assign legal    = (code[7:6] == 2'b00) && (code[4] == prec_dbl) && nib_ok;
endmodule

// File: rtl/fcmp_class.sv
module fcmp_class #(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23,
  localparam int MAG_W = EXP_W + FRAC_W,
  localparam int OP_W  = MAG_W + 1
) (
  input  logic [OP_W-1:0] a,
  input  logic [OP_W-1:0] b,
  output logic            unord,
  output logic            eq,
  output logic            lt
);
  logic [MAG_W-1:0] mag_a, mag_b;
  logic             sgn_a, sgn_b;
  logic             nan_a, nan_b;
  logic             zeros;

  assign sgn_a = a[OP_W-1];
  assign sgn_b = b[OP_W-1];
  assign mag_a = a[MAG_W-1:0];
  assign mag_b = b[MAG_W-1:0];
  assign nan_a = (&a[MAG_W-1:FRAC_W]) && (|a[FRAC_W-1:0]);
  assign nan_b = (&b[MAG_W-1:FRAC_W]) && (|b[FRAC_W-1:0]);
  assign unord = nan_a || nan_b;
  assign zeros = (mag_a == '0) && (mag_b == '0);
  assign eq    = zeros || (a == b);

  always_comb begin
    if (zeros)              lt = 1'b0;
    else if (sgn_a != sgn_b) lt = sgn_a;
    else if (sgn_a)          lt = (mag_a > mag_b);
    else                     lt = (mag_a < mag_b);
  end
endmodule

// File: rtl/fcmp_eval.sv
module fcmp_eval
  import fcmp_pkg::*;
(
  input  pred_e pred,
  input  logic  unord_or,
  input  logic  unord,
  input  logic  eq,
  input  logic  lt,
  output logic  flag
);
  logic ord;

  always_comb begin
    case (pred)
      PRD_EQ:  ord = !unord && eq;
      PRD_NE:  ord = unord || !eq;
      PRD_GT:  ord = !unord && !eq && !lt;
      PRD_GE:  ord = !unord && !lt;
      PRD_LT:  ord = !unord && lt;
      PRD_LE:  ord = !unord && (lt || eq);
      default: ord = 1'b0;
    endcase
    flag = unord_or ? (unord || ord) : ord;
  end
endmodule

// File: rtl/fcmp_flag_unit.sv
module fcmp_flag_unit
  import fcmp_pkg::*;
#(
  parameter int SP_EXP  = 8,
  parameter int SP_FRAC = 23,
  parameter int DP_EXP  = 11,
  parameter int DP_FRAC = 52,
  localparam int SP_W   = 1 + SP_EXP + SP_FRAC,
  localparam int DP_W   = 1 + DP_EXP + DP_FRAC
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            in_valid,
  input  logic [7:0]      func_code,
  input  logic            prec_dbl,
  input  logic [DP_W-1:0] opnd_a,
  input  logic [DP_W-1:0] opnd_b,
  output logic            flag_q,
  output logic            flag_we
);
  logic  legal, unord_or;
  pred_e pred;
  logic  sp_un, sp_eq, sp_lt;
  logic  dp_un, dp_eq, dp_lt;
  logic  sel_un, sel_eq, sel_lt;
  logic  flag_n;

  fcmp_decode u_dec (
    .code(func_code), .prec_dbl(prec_dbl),
    .legal(legal), .unord_or(unord_or), .pred(pred)
  );

  fcmp_class #(.EXP_W(SP_EXP), .FRAC_W(SP_FRAC)) u_sp (
    .a(opnd_a[SP_W-1:0]), .b(opnd_b[SP_W-1:0]),
    .unord(sp_un), .eq(sp_eq), .lt(sp_lt)
  );

  fcmp_class #(.EXP_W(DP_EXP), .FRAC_W(DP_FRAC)) u_dp (
    .a(opnd_a), .b(opnd_b),
    .unord(dp_un), .eq(dp_eq), .lt(dp_lt)
  );

  assign sel_un = prec_dbl ? dp_un : sp_un;
  assign sel_eq = prec_dbl ? dp_eq : sp_eq;
  assign sel_lt = prec_dbl ? dp_lt : sp_lt;

  fcmp_eval u_eval (
    .pred(pred), .unord_or(unord_or), .unord(sel_un),
    .eq(sel_eq), .lt(sel_lt), .flag(flag_n)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q  <= 1'b0;
      flag_we <= 1'b0;
    end else begin
      flag_we <= in_valid && legal;
      if (in_valid && legal) flag_q <= flag_n;
    end
  end
endmodule

// File: rtl/fcmp_flag_chk.sv
module fcmp_flag_chk #(
  parameter int SP_EXP  = 8,
  parameter int SP_FRAC = 23,
  parameter int DP_EXP  = 11,
  parameter int DP_FRAC = 52,
  localparam int SP_W   = 1 + SP_EXP + SP_FRAC,
  localparam int DP_W   = 1 + DP_EXP + DP_FRAC
) (
  input logic            clk,
  input logic            rst,
  input logic            in_valid,
  input logic [7:0]      func_code,
  input logic            prec_dbl,
  input logic [DP_W-1:0] opnd_a,
  input logic [DP_W-1:0] opnd_b,
  input logic            flag_q,
  input logic            flag_we
);
  logic a_sp_nan, a_dp_nan, sp_zero_pair;

  assign a_sp_nan = (opnd_a[SP_W-2:SP_FRAC] == '1) && (opnd_a[SP_FRAC-1:0] != '0);
  assign a_dp_nan = (opnd_a[DP_W-2:DP_FRAC] == '1) && (opnd_a[DP_FRAC-1:0] != '0);
  assign sp_zero_pair = (opnd_a[SP_W-2:0] == '0) && (opnd_b[SP_W-2:0] == '0);

  AST_IDLE_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !flag_we); // R2
  AST_ORD_NAN_FALSE: assert property (@(posedge clk) disable iff (rst)
    in_valid && func_code == 8'h18 && prec_dbl && a_dp_nan |=> flag_we && !flag_q); // R3
  AST_PURE_UNORD: assert property (@(posedge clk) disable iff (rst)
    in_valid && func_code == 8'h2E && !prec_dbl && a_sp_nan |=> flag_we && flag_q); // R5
  AST_SIGNED_ZERO_EQ: assert property (@(posedge clk) disable iff (rst)
    in_valid && func_code == 8'h08 && !prec_dbl && sp_zero_pair |=> flag_we && flag_q); // R6
  AST_BAD_CODE: assert property (@(posedge clk) disable iff (rst)
    in_valid && (func_code[7:6] != 2'b00 || func_code[4] != prec_dbl) |=> !flag_we); // R8
  AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (rst)
    !flag_we |-> $stable(flag_q)); // R10
endmodule

bind fcmp_flag_unit fcmp_flag_chk #(
  .SP_EXP(SP_EXP), .SP_FRAC(SP_FRAC), .DP_EXP(DP_EXP), .DP_FRAC(DP_FRAC)
) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .func_code(func_code),
  .prec_dbl(prec_dbl), .opnd_a(opnd_a), .opnd_b(opnd_b),
  .flag_q(flag_q), .flag_we(flag_we)
);

// File: tb/fcmp_flag_unit_bench.sv
module fcmp_flag_unit_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [7:0]  func_code = '0;
  logic        prec_dbl = 1'b0;
  logic [63:0] opnd_a = '0, opnd_b = '0;
  logic        flag_q, flag_we;

  int n_chk = 0, n_fail = 0;
  logic exp_flag = 1'b0;

  always #2 clk = ~clk;

  fcmp_flag_unit u_fcmp_flag_unit (
    .clk(clk), .rst(rst), .in_valid(in_valid), .func_code(func_code),
    .prec_dbl(prec_dbl), .opnd_a(opnd_a), .opnd_b(opnd_b),
    .flag_q(flag_q), .flag_we(flag_we)
  );

  task automatic chk(input string tag, input logic got, input logic expv);
    n_chk++;
    if (got !== expv) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b", tag, got, expv);
    end
  endtask

  function automatic bit is_nan(input logic [63:0] x, input bit dbl);
    if (dbl) return (x[62:52] == 11'h7FF) && (x[51:0] != 0);
    return (x[30:23] == 8'hFF) && (x[22:0] != 0);
  endfunction

  // monotonic key: equal for both zeros, ordered like the real values
  function automatic logic [63:0] key(input logic [63:0] x, input bit dbl);
    logic [63:0] mag;
    logic s;
    mag = dbl ? {1'b0, x[62:0]} : {33'd0, x[30:0]};
    s   = dbl ? x[63] : x[31];
    return s ? (64'h8000_0000_0000_0000 - mag) : (64'h8000_0000_0000_0000 + mag);
  endfunction

  // returns {legal, flag}
  function automatic logic [1:0] ref_eval(input logic [7:0] c, input logic [63:0] a,
                                          input logic [63:0] b, input bit d);
    bit un, r, leg;
    logic [63:0] ka, kb;
    un = is_nan(a, d) || is_nan(b, d);
    ka = key(a, d);
    kb = key(b, d);
    leg = (c[7:6] == 0) && (c[4] == d) &&
          ((c[3:0] >= 8 && c[3:0] <= 13) || (c[3:0] == 14 && c[5]));
    case (c[3:0])
      4'h8: r = !un && ka == kb;
      4'h9: r = un || ka != kb;
      4'hA: r = !un && ka > kb;
      4'hB: r = !un && ka >= kb;
      4'hC: r = !un && ka < kb;
      4'hD: r = !un && ka <= kb;
      default: r = 1'b0;
    endcase
    if (c[5]) r = r || un;
    return {leg, r};
  endfunction

  task automatic run_op(input string tag, input logic [7:0] c, input logic [63:0] a,
                        input logic [63:0] b, input bit d);
    logic [1:0] rv;
    rv = ref_eval(c, a, b, d);
    @(negedge clk);
    in_valid = 1'b1; func_code = c; opnd_a = a; opnd_b = b; prec_dbl = d;
    @(negedge clk);
    in_valid = 1'b0;
    if (rv[1]) exp_flag = rv[0];
    chk({tag, " we"}, flag_we, rv[1]);
    chk({tag, " flag"}, flag_q, exp_flag);
  endtask

  function automatic logic [63:0] pick(input int k, input logic [63:0] other, input bit d);
    logic [63:0] r;
    r = {$urandom, $urandom};
    case (k)
      0: r = d ? 64'h0 : {32'h0, 32'h0};
      1: r = d ? 64'h8000_0000_0000_0000 : 64'h8000_0000;
      2: r = d ? 64'h7FF0_0000_0000_0000 : 64'h7F80_0000;
      3: r = d ? 64'hFFF0_0000_0000_0000 : 64'hFF80_0000;
      4: r = d ? (64'h7FF8_0000_0000_0000 | (r & 64'h8007_FFFF_FFFF_FFFF))
               : (64'h7FC0_0000 | (r & 64'h803F_FFFF));
      5: r = other;
      6: r = d ? (other ^ 64'h8000_0000_0000_0000) : (other ^ 64'h8000_0000);
      default: ;
    endcase
    if (!d) r[63:32] = $urandom;
    return r;
  endfunction

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin : stim
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    chk("R9 reset flag_q", flag_q, 1'b0);
    chk("R9 reset flag_we", flag_we, 1'b0);
    rst = 1'b0;

    run_op("R1 sp gt 2>1", 8'h0A, 64'h4000_0000, 64'h3F80_0000, 1'b0);
    run_op("R1 dp lt 1<2", 8'h1C, 64'h3FF0_0000_0000_0000, 64'h4000_0000_0000_0000, 1'b1);
    @(negedge clk);
    chk("R2 we one cycle", flag_we, 1'b0);
    run_op("R6 sp +0==-0", 8'h08, 64'h0, 64'h8000_0000, 1'b0);
    run_op("R6 dp +0 lt -0", 8'h1C, 64'h0, 64'h8000_0000_0000_0000, 1'b1);
    run_op("R7 sp -2<-1", 8'h0C, 64'hC000_0000, 64'hBF80_0000, 1'b0);
    run_op("R7 dp -1>-3", 8'h1A, 64'hBFF0_0000_0000_0000, 64'hC008_0000_0000_0000, 1'b1);
    run_op("R3 sp ne nan", 8'h09, 64'h7FC0_0000, 64'h7FC0_0000, 1'b0);
    run_op("R3 dp ge nan", 8'h1B, 64'h1, 64'h7FF0_0000_0000_0001, 1'b1);
    run_op("R4 sp ueq nan", 8'h28, 64'h3F80_0000, 64'hFFC0_0001, 1'b0);
    run_op("R4 dp ult no nan", 8'h3C, 64'h4000_0000_0000_0000, 64'h3FF0_0000_0000_0000, 1'b1);
    run_op("R5 dp un none", 8'h3E, 64'h7FF0_0000_0000_0000, 64'h0, 1'b1);
    run_op("R5 sp un nan", 8'h2E, 64'h0, 64'h7F80_0001, 1'b0);
    run_op("R8 code 0x0E", 8'h0E, 64'h0, 64'h0, 1'b0);
    run_op("R8 prec mismatch", 8'h18, 64'h0, 64'h0, 1'b0);
    run_op("R8 high bits", 8'h48, 64'h0, 64'h0, 1'b0);
    repeat (4) @(negedge clk);
    chk("R10 hold", flag_q, exp_flag);

    for (int i = 0; i < 3000; i++) begin
      logic [63:0] a, b;
      logic [7:0] c;
      bit d;
      d = $urandom_range(1, 0);
      a = pick($urandom_range(9, 0), 64'h3FF0_0000_0000_0000, d);
      b = pick($urandom_range(9, 0), a, d);
      c = {2'b00, 1'($urandom_range(1, 0)), d, 4'($urandom_range(14, 8))};
      if ($urandom_range(15, 0) == 0) c = 8'($urandom);
      run_op("R1/R4 random", c, a, b, d);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule